// File: doc/BRIEF.md
# SPI Flash Command Engine

This block turns single memory-style bus accesses into complete serial flash transactions. A read or write aimed at a chip select's window is expanded into an SPI frame: the chip select is pulled low, an opcode byte goes out, then a 3- or 4-byte address, then one to four data bytes, and finally the chip select is released. A raw mode for each chip select shifts bus bytes straight onto the wire. In that mode no opcode or address is sent, and software holds the chip select level through its control word.

Each chip select has a control word, a write-enable bit, an extended-address bit and a window size. These arrive as inputs from the surrounding register file. The engine handles one access at a time. The bus request is held until `req_ready_o` pulses for one cycle, and that pulse comes only after the chip select has gone high again. An error pulse is raised alongside the ready pulse when an access is refused or suspicious.

Top module: `spi_flash_cmd_engine`

## Requirements
- R1: When the chip select's mode field (control bits 1:0) is 0 (plain read), the opcode sent is 0x03 whatever control bits 23:16 hold. The opcode is followed by address bytes [23:16], [15:8] and [7:0], each most significant bit first.
- R2: Mode 1 (fast read) and mode 2 (write) send control bits 23:16 as the opcode byte. A read is allowed in modes 0 and 1, and a write is allowed in mode 2.
- R3: With 4-byte addressing enabled, address byte [31:24] is sent between the opcode and byte [23:16]. The enable is control bit 13 of chip select 0 when ADDR4_PER_CS=0, and otherwise it is that chip select's `cfg_addr4_i` bit.
- R4: The address is ANDed with 2^n-1, where n is the chip select's 5-bit `seg_log2_i` field. If any address bit outside that mask is set, the error pulse is raised and the frame still goes out with the masked address.
- R5: `req_size_i` gives the number of data bytes, from 1 to 4. Data byte i is shifted from or returned into bus bits [8i+7:8i], with byte 0 on the wire first. Unused read bits return 0, and a write returns 0 read data.
- R6: In mode 3 (raw), only data bytes are shifted. A read sends 0x00 for each byte, and CS_n of that chip select equals control bit 2 at all times.
- R7: A write to a chip select whose `cfg_wen_i` bit is 0 completes with no SPI activity, no chip select movement and no error.
- R8: A read in mode 2, a write in mode 0 or 1, or a size outside 1..4 completes with no SPI activity, read data 0 and the error pulse.
- R9: A zero opcode in mode 1 or 2 raises the error pulse, and the frame is still sent.
- R10: In modes 0 to 2, CS_n of the addressed chip select is high when idle and low for the whole frame. No other non-raw chip select goes low. Ready is returned only after it is high again.
- R11: The SPI timing is mode 0. SCLK idles low and each half period lasts SCLK_DIV clocks. MOSI is stable while SCLK is high, and MISO is sampled on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request, held until ready |
| req_ready_o | output | 1 | One-cycle completion pulse |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_cs_i | input | CS_W | Chip select index |
| req_addr_i | input | 32 | Byte address within the window |
| req_size_i | input | 3 | Data byte count (1..4) |
| req_wdata_i | input | 32 | Write data, byte 0 in bits 7:0 |
| rsp_rdata_o | output | 32 | Read data, valid with ready |
| rsp_err_o | output | 1 | Error pulse, valid with ready |
| ctrl_i | input | 32*NUM_CS | Control word for each chip select |
| cfg_wen_i | input | NUM_CS | Write enable for each chip select |
| cfg_addr4_i | input | NUM_CS | 4-byte address select for each chip select |
| seg_log2_i | input | 5*NUM_CS | log2 of window size for each chip select |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data out |
| miso_i | input | 1 | SPI data in |
| cs_n_o | output | NUM_CS | Chip selects, active low |

## Verification
A flash model in the bench returns a known byte pattern and records every byte seen on MOSI. Each frame is compared byte for byte with one built from the requirements.

The corner cases chosen each catch a specific fault:
- A read-mode access whose opcode field is set to another value catches a design that forgets to force 0x03.
- A read-mode access whose opcode field is zero catches a design that raises a spurious zero-opcode error.
- Setting the global 4-byte bit on chip select 0 while addressing chip select 1 catches a lost or misplaced top address byte.
- An address outside a small window catches missing masking or a missing error pulse.
- A raw-mode transfer catches an opcode or address leaking into it, and a chip select that does not follow software.
- Writes that are disabled or in the wrong mode must leave the wire silent.
- Every clock, the bench checks that idle chip selects are high and that SCLK high phases last exactly the divider length.

// File: rtl/sfce_pkg.sv
package sfce_pkg;
  localparam int SEG_W      = 5;
  localparam int MODE_LSB   = 0;
  localparam int STOP_BIT   = 2;
  localparam int ADDR4_BIT  = 13;
  localparam int CMD_LSB    = 16;
  localparam logic [7:0] READ_OPCODE = 8'h03;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_FREAD = 2'd1,
    MODE_WRITE = 2'd2,
    MODE_RAW   = 2'd3
  } sfce_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_LOAD, ST_WAIT, ST_DESEL, ST_RESP
  } sfce_state_e;
endpackage

// File: rtl/sfce_decode.sv
module sfce_decode
  import sfce_pkg::*;
(
  input  logic              wr_i,
  input  logic [1:0]        mode_i,
  input  logic [7:0]        cmd_i,
  input  logic              wen_i,
  input  logic [2:0]        size_i,
  input  logic [31:0]       addr_i,
  input  logic [SEG_W-1:0]  seg_log2_i,
  output logic              go_o,
  output logic              raw_o,
  output logic              err_o,
  output logic [7:0]        opcode_o,
  output logic [31:0]       addr_o
);
  logic [31:0] mask;
  logic        size_ok;

  assign mask    = (32'h1 << seg_log2_i) - 32'h1;
  assign size_ok = (size_i != 3'd0) && (size_i <= 3'd4);
  assign addr_o  = addr_i & mask;

  always_comb begin
    go_o     = 1'b0;
    raw_o    = 1'b0;
    err_o    = 1'b0;
    opcode_o = cmd_i;
    if (!size_ok) begin
      err_o = 1'b1;
    end else if (wr_i && !wen_i) begin
      go_o = 1'b0;  // silently dropped
    end else begin
      unique case (sfce_mode_e'(mode_i))
        MODE_READ:  begin go_o = !wr_i; err_o = wr_i; opcode_o = READ_OPCODE; end
        MODE_FREAD: begin go_o = !wr_i; err_o = wr_i; end
        MODE_WRITE: begin go_o = wr_i;  err_o = !wr_i; end
        MODE_RAW:   begin go_o = 1'b1;  raw_o = 1'b1; end
        default:    err_o = 1'b1;
      endcase
    end
    if (go_o && !raw_o && (opcode_o == 8'h00))         err_o = 1'b1;
    if (go_o && !raw_o && ((addr_i & ~mask) != 32'h0)) err_o = 1'b1;
  end
endmodule

// File: rtl/sfce_byte_shifter.sv
module sfce_byte_shifter #(
  parameter int SCLK_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int CNT_W = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SCLK_DIV - 1);

  logic             busy_q, sclk_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; sclk_q <= 1'b0; done_q <= 1'b0;
      cnt_q  <= '0;   bit_q  <= '0;   sh_q   <= '0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        sh_q   <= tx_i;
        cnt_q  <= '0;
        bit_q  <= '0;
        sclk_q <= 1'b0;
      end else if (busy_q) begin
        if (cnt_q == CNT_LAST) begin
          cnt_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[6:0], miso_i};
          end else begin
            sclk_q <= 1'b0;
            sh_q   <= {sh_q[6:0], 1'b0};
            if (bit_q == 3'd7) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
            end
          end
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = busy_q & sh_q[7];
  assign done_o = done_q;
  assign rx_o   = rx_q;

  // R11: a byte ends on a falling SCLK edge
  p_done_on_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!sclk_q && $past(sclk_q)));
endmodule

// File: rtl/spi_flash_cmd_engine.sv
module spi_flash_cmd_engine
  import sfce_pkg::*;
#(
  parameter int NUM_CS       = 2,
  parameter int SCLK_DIV     = 2,
  parameter bit ADDR4_PER_CS = 1'b0,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic                    req_write_i,
  input  logic [CS_W-1:0]         req_cs_i,
  input  logic [31:0]             req_addr_i,
  input  logic [2:0]              req_size_i,
  input  logic [31:0]             req_wdata_i,
  output logic [31:0]             rsp_rdata_o,
  output logic                    rsp_err_o,
  input  logic [NUM_CS*32-1:0]    ctrl_i,
  input  logic [NUM_CS-1:0]       cfg_wen_i,
  input  logic [NUM_CS-1:0]       cfg_addr4_i,
  input  logic [NUM_CS*SEG_W-1:0] seg_log2_i,
  output logic                    sclk_o,
  output logic                    mosi_o,
  input  logic                    miso_i,
  output logic [NUM_CS-1:0]       cs_n_o
);
  logic [31:0]      ctrl_a [NUM_CS];
  logic [SEG_W-1:0] seg_a  [NUM_CS];
  logic [NUM_CS-1:0] raw_mask, stop_q;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign ctrl_a[g]   = ctrl_i[g*32 +: 32];
    assign seg_a[g]    = seg_log2_i[g*SEG_W +: SEG_W];
    assign raw_mask[g] = (ctrl_a[g][MODE_LSB +: 2] == MODE_RAW);
    assign cs_n_o[g]   = raw_mask[g] ? ctrl_a[g][STOP_BIT] : stop_q[g];
    logic unused_ctrl_bits;
    assign unused_ctrl_bits = ^{ctrl_a[g][31:24], ctrl_a[g][15:3]};
  end

  // request decode
  logic            cs_ok;
  logic [CS_W-1:0] sel_idx;
  logic            dec_go, dec_raw, dec_err, addr4;
  logic [7:0]      dec_op;
  logic [31:0]     dec_addr;
  logic [2:0]      hdr_n;
  logic [39:0]     hdr_bytes;

  assign cs_ok   = int'(req_cs_i) < NUM_CS;
  assign sel_idx = cs_ok ? req_cs_i : '0;
  assign addr4   = ADDR4_PER_CS ? cfg_addr4_i[sel_idx] : ctrl_a[0][ADDR4_BIT];

  sfce_decode u_decode (
    .wr_i       (req_write_i),
    .mode_i     (ctrl_a[sel_idx][MODE_LSB +: 2]),
    .cmd_i      (ctrl_a[sel_idx][CMD_LSB +: 8]),
    .wen_i      (cfg_wen_i[sel_idx]),
    .size_i     (cs_ok ? req_size_i : 3'd0),
    .addr_i     (req_addr_i),
    .seg_log2_i (seg_a[sel_idx]),
    .go_o       (dec_go),
    .raw_o      (dec_raw),
    .err_o      (dec_err),
    .opcode_o   (dec_op),
    .addr_o     (dec_addr)
  );

  assign hdr_n     = dec_raw ? 3'd0 : (addr4 ? 3'd5 : 3'd4);
  assign hdr_bytes = addr4 ? {dec_op, dec_addr} : {dec_op, dec_addr[23:0], 8'h00};

  // frame sequencer
  sfce_state_e     st_q;
  logic [CS_W-1:0] sel_q;
  logic            wr_q, raw_q, err_q;
  logic [39:0]     hdr_q;
  logic [2:0]      hdr_n_q;
  logic [3:0]      idx_q, total_q;
  logic [31:0]     wdata_q, rdata_q;
  logic            is_hdr, sh_done;
  logic [1:0]      dbyte;
  logic [7:0]      tx_byte, sh_rx;

  assign is_hdr  = idx_q < {1'b0, hdr_n_q};
  assign dbyte   = 2'(idx_q - {1'b0, hdr_n_q});
  assign tx_byte = is_hdr ? hdr_q[39:32] : (wr_q ? wdata_q[7:0] : 8'h00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE; sel_q <= '0; wr_q <= 1'b0; raw_q <= 1'b0; err_q <= 1'b0;
      hdr_q   <= '0; hdr_n_q <= '0; idx_q <= '0; total_q <= '0;
      wdata_q <= '0; rdata_q <= '0; stop_q <= '1;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          sel_q   <= sel_idx;
          wr_q    <= req_write_i;
          raw_q   <= dec_raw;
          err_q   <= dec_err;
          rdata_q <= '0;
          wdata_q <= req_wdata_i;
          hdr_q   <= hdr_bytes;
          hdr_n_q <= hdr_n;
          idx_q   <= '0;
          total_q <= {1'b0, hdr_n} + {1'b0, req_size_i};
          if (!dec_go)     st_q <= ST_RESP;
          else if (dec_raw) st_q <= ST_LOAD;
          else begin
            stop_q[sel_idx] <= 1'b0;
            st_q            <= ST_SEL;
          end
        end
        ST_SEL:  st_q <= ST_LOAD;
        ST_LOAD: st_q <= ST_WAIT;
        ST_WAIT: if (sh_done) begin
          if (is_hdr) hdr_q <= {hdr_q[31:0], 8'h00};
          else begin
            wdata_q <= {8'h00, wdata_q[31:8]};
            if (!wr_q) rdata_q[{dbyte, 3'b000} +: 8] <= sh_rx;
          end
          if (idx_q == total_q - 4'd1) st_q <= ST_DESEL;
          else begin
            idx_q <= idx_q + 4'd1;
            st_q  <= ST_LOAD;
          end
        end
        ST_DESEL: begin
          if (!raw_q) stop_q[sel_q] <= 1'b1;
          st_q <= ST_RESP;
        end
        ST_RESP: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  sfce_byte_shifter #(.SCLK_DIV(SCLK_DIV)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (st_q == ST_LOAD),
    .tx_i    (tx_byte),
    .miso_i  (miso_i),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .done_o  (sh_done),
    .rx_o    (sh_rx)
  );

  assign req_ready_o = (st_q == ST_RESP);
  assign rsp_err_o   = req_ready_o & err_q;
  assign rsp_rdata_o = rdata_q;

  // R10: ready only once every command-mode chip select is released
  p_ready_cs_released_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> &(cs_n_o | raw_mask));
  // R10: never two command-mode chip selects low together
  p_single_cs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o & ~raw_mask));
  // R11: MOSI held while SCLK is high
  p_mosi_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
  // R10: clocking in a command mode only with a chip select low
  p_sclk_with_cs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && !raw_q) |-> ((~cs_n_o & ~raw_mask) != '0));
  // R5: write returns zero read data
  p_write_no_rdata_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && wr_q) |-> (rsp_rdata_o == 32'h0));
endmodule

// File: tb/spi_flash_cmd_engine_tb_top.sv
module spi_flash_cmd_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CS     = 2;
  localparam int DIV        = 2;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [0:0]  req_cs_i = '0;
  logic [31:0] req_addr_i = '0, req_wdata_i = '0;
  logic [2:0]  req_size_i = '0;
  logic        req_ready_o, rsp_err_o, sclk_o, mosi_o, miso_i = 1'b0;
  logic [31:0] rsp_rdata_o;
  logic [NUM_CS-1:0] cs_n_o, cfg_wen = '0, cfg_addr4 = '0;
  logic [31:0] ctrl_r [NUM_CS];
  logic [4:0]  seg_r  [NUM_CS];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flash_cmd_engine #(.NUM_CS(NUM_CS), .SCLK_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
    .req_cs_i(req_cs_i), .req_addr_i(req_addr_i), .req_size_i(req_size_i),
    .req_wdata_i(req_wdata_i), .rsp_rdata_o(rsp_rdata_o), .rsp_err_o(rsp_err_o),
    .ctrl_i({ctrl_r[1], ctrl_r[0]}), .cfg_wen_i(cfg_wen), .cfg_addr4_i(cfg_addr4),
    .seg_log2_i({seg_r[1], seg_r[0]}),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i), .cs_n_o(cs_n_o)
  );

  int checks = 0, fails = 0;
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] cur = '0;
  int  bitc = 0, hi_len = 0;
  bit  active = 1'b0, prev_sclk = 1'b0, prev_mosi = 1'b0;
  logic [NUM_CS-1:0] cs_seen = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int j);
    return 8'h3C + 8'(j * 71);
  endfunction

  function automatic logic [NUM_CS-1:0] idle_cs();
    logic [NUM_CS-1:0] v;
    for (int g = 0; g < NUM_CS; g++)
      v[g] = (ctrl_r[g][1:0] == 2'd3) ? ctrl_r[g][2] : 1'b1;
    return v;
  endfunction

  function automatic logic [NUM_CS-1:0] cmd_mask();
    logic [NUM_CS-1:0] v;
    for (int g = 0; g < NUM_CS; g++) v[g] = (ctrl_r[g][1:0] != 2'd3);
    return v;
  endfunction

  // flash model and per-clock comparison
  always @(negedge clk) begin
    if (rst_ni) begin
      cs_seen = cs_seen | (~cs_n_o & cmd_mask());
      if (sclk_o && !prev_sclk) begin
        cur = {cur[6:0], mosi_o};
        bitc++;
        hi_len = 1;
        if (bitc == 8) begin got_q.push_back(cur); bitc = 0; end
      end else if (sclk_o) begin
        hi_len++;
        chk(mosi_o == prev_mosi, "R11", "mosi moved while sclk high", mosi_o, prev_mosi);
      end
      if (!sclk_o && prev_sclk)
        chk(hi_len == DIV, "R11", "sclk high length", hi_len, DIV);
      if (!active)
        chk(!sclk_o && cs_n_o == idle_cs(), "R10", "idle pins {sclk,cs_n}",
            {sclk_o, cs_n_o}, {1'b0, idle_cs()});
      if (!sclk_o) miso_i = pat(got_q.size())[7 - bitc];
      prev_sclk = sclk_o;
      prev_mosi = mosi_o;
    end
  end

  task automatic ex(input logic [7:0] b);
    exp_q.push_back(b);
  endtask

  task automatic access(input bit wr, input int cs, input logic [31:0] addr,
                        input int size, input logic [31:0] wdata,
                        output logic [31:0] rdata, output bit err);
    @(negedge clk);
    got_q.delete(); exp_q.delete();
    cs_seen = '0; bitc = 0; active = 1'b1;
    req_write_i = wr; req_cs_i = 1'(cs); req_addr_i = addr;
    req_size_i = 3'(size); req_wdata_i = wdata; req_valid_i = 1'b1;
    do @(negedge clk); while (!req_ready_o);
    rdata = rsp_rdata_o; err = rsp_err_o;
    req_valid_i = 1'b0; active = 1'b0;
  endtask

  task automatic check_frame(input string req);
    chk(got_q.size() == exp_q.size(), req, "frame length", got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], req, $sformatf("frame byte %0d", i), got_q[i], exp_q[i]);
  endtask

  function automatic logic [31:0] mk_ctrl(input int mode, input logic [7:0] cmd, input bit stop);
    return {8'h00, cmd, 13'h0, stop, 2'(mode)};
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk(1'b0, "R10", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    bit er;
    for (int g = 0; g < NUM_CS; g++) begin ctrl_r[g] = mk_ctrl(0, 8'h00, 1'b1); seg_r[g] = 5'd24; end
    repeat (3) @(negedge clk);
    chk(cs_n_o == '1 && !sclk_o && !req_ready_o && !rsp_err_o, "R10", "reset outputs",
        {cs_n_o, sclk_o, req_ready_o, rsp_err_o}, {2'b11, 3'b000});
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R1: read mode forces 0x03, field ignored
    ctrl_r[0] = mk_ctrl(0, 8'hBB, 1'b1);
    access(0, 0, 32'h0012_3456, 4, 0, rd, er);
    ex(8'h03); ex(8'h12); ex(8'h34); ex(8'h56); repeat (4) ex(8'h00);
    check_frame("R1");
    chk(rd == {pat(7), pat(6), pat(5), pat(4)}, "R5", "read data 4B", rd, {pat(7), pat(6), pat(5), pat(4)});
    chk(!er, "R1", "no error", er, 0);
    chk(cs_seen == 2'b01, "R10", "only cs0 selected", cs_seen, 2'b01);

    // R2: fast read uses field
    ctrl_r[1] = mk_ctrl(1, 8'h0B, 1'b1);
    access(0, 1, 32'h00AB_CDEF, 2, 0, rd, er);
    ex(8'h0B); ex(8'hAB); ex(8'hCD); ex(8'hEF); ex(8'h00); ex(8'h00);
    check_frame("R2");
    chk(rd == {16'h0, pat(5), pat(4)}, "R5", "read data 2B", rd, {16'h0, pat(5), pat(4)});
    chk(cs_seen == 2'b10, "R10", "only cs1 selected", cs_seen, 2'b10);

    // R2/R5: write lane order
    ctrl_r[0] = mk_ctrl(2, 8'h02, 1'b1); cfg_wen = 2'b01;
    access(1, 0, 32'h0000_0100, 3, 32'h55C0_FFEE, rd, er);
    ex(8'h02); ex(8'h00); ex(8'h01); ex(8'h00); ex(8'hEE); ex(8'hFF); ex(8'hC0);
    check_frame("R5");
    chk(rd == 0 && !er, "R5", "write rdata/err", {rd, 31'h0, er}, 0);

    // R3: global 4-byte bit on cs0 applies to cs1; zero field in read mode is no error
    ctrl_r[0] = mk_ctrl(0, 8'h00, 1'b1) | 32'h2000;
    ctrl_r[1] = mk_ctrl(0, 8'h00, 1'b1); seg_r[1] = 5'd25;
    access(0, 1, 32'h01AB_CDEF, 1, 0, rd, er);
    ex(8'h03); ex(8'h01); ex(8'hAB); ex(8'hCD); ex(8'hEF); ex(8'h00);
    check_frame("R3");
    chk(rd == {24'h0, pat(5)}, "R3", "read data after 4B addr", rd, {24'h0, pat(5)});
    chk(!er, "R9", "read mode zero field no error", er, 0);

    // R4: window mask
    ctrl_r[0] = mk_ctrl(0, 8'h00, 1'b1); seg_r[0] = 5'd16;
    access(0, 0, 32'h0034_5678, 2, 0, rd, er);
    ex(8'h03); ex(8'h00); ex(8'h56); ex(8'h78); ex(8'h00); ex(8'h00);
    check_frame("R4");
    chk(er, "R4", "out-of-window error", er, 1);
    chk(rd == {16'h0, pat(5), pat(4)}, "R4", "masked read data", rd, {16'h0, pat(5), pat(4)});

    // R6: raw read, software-held CS
    ctrl_r[1] = mk_ctrl(3, 8'h9F, 1'b0);
    @(negedge clk);
    chk(cs_n_o == 2'b01, "R6", "raw cs follows bit", cs_n_o, 2'b01);
    access(0, 1, 32'hFFFF_FFFF, 2, 0, rd, er);
    ex(8'h00); ex(8'h00);
    check_frame("R6");
    chk(rd == {16'h0, pat(1), pat(0)} && !er, "R6", "raw read data", rd, {16'h0, pat(1), pat(0)});
    chk(cs_n_o == 2'b01, "R6", "raw cs held after", cs_n_o, 2'b01);
    cfg_wen = 2'b10;
    access(1, 1, 0, 4, 32'h1122_3344, rd, er);
    ex(8'h44); ex(8'h33); ex(8'h22); ex(8'h11);
    check_frame("R6");
    ctrl_r[1] = mk_ctrl(3, 8'h9F, 1'b1);
    @(negedge clk);
    chk(cs_n_o == 2'b11, "R6", "raw cs released by bit", cs_n_o, 2'b11);

    // R7: write not enabled
    ctrl_r[0] = mk_ctrl(2, 8'h02, 1'b1); cfg_wen = 2'b10;
    access(1, 0, 0, 4, 32'hDEAD_BEEF, rd, er);
    check_frame("R7");
    chk(!er && cs_seen == 0, "R7", "dropped write {err,cs}", {er, cs_seen}, 0);

    // R8: wrong direction / size
    cfg_wen = 2'b11;
    access(0, 0, 0, 2, 0, rd, er);
    check_frame("R8");
    chk(er && rd == 0 && cs_seen == 0, "R8", "read in write mode", {er, rd}, {1'b1, 32'h0});
    ctrl_r[0] = mk_ctrl(0, 8'h00, 1'b1);
    access(1, 0, 0, 2, 32'h1234, rd, er);
    check_frame("R8");
    chk(er && cs_seen == 0, "R8", "write in read mode", er, 1);
    access(0, 0, 0, 0, 0, rd, er);
    check_frame("R8");
    chk(er && rd == 0, "R8", "size zero", {er, rd}, {1'b1, 32'h0});

    // R9: zero opcode still sent
    ctrl_r[0] = mk_ctrl(1, 8'h00, 1'b1); seg_r[0] = 5'd24;
    access(0, 0, 32'h0000_0010, 1, 0, rd, er);
    ex(8'h00); ex(8'h00); ex(8'h00); ex(8'h10); ex(8'h00);
    check_frame("R9");
    chk(er, "R9", "zero opcode error", er, 1);
    chk(rd == {24'h0, pat(4)}, "R9", "read data", rd, {24'h0, pat(4)});

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule